// File: doc/BRIEF.md
# Multi-CPU Interrupt Distributor

This block gathers peripheral interrupt lines and software-raised interrupts and decides, for each CPU of a small multiprocessor, which single interrupt that CPU should service next. Every interrupt ID has an enable bit, a pending bit, an active bit, a priority, a set of target CPUs and a trigger mode. All of these sit behind a 32-bit register bus with byte enables. IDs 0 to 15 are software interrupts. Their pending and active state is kept separately for each CPU. IDs 16 to 31 are level-sensitive peripheral lines. IDs 32 and up are shared peripheral lines whose trigger mode can be set to edge or level.

Each CPU sees a candidate: a valid flag, an ID and a priority. The acknowledge logic outside this block pulses `cpu_take` to claim the candidate on offer. This clears the pending state and marks the interrupt active. Later it pulses `cpu_done` with an ID to end the active state. Reads are combinational. Writes take effect at the clock edge on which `bus_sel` and `bus_wr` are high. Accesses whose two low address bits are not zero are ignored.

Top module: `irq_distributor`

## Requirements
- R1: After reset, the following are all zero: the control register, every enable, pending and active bit, every priority, every target and every shared trigger bit. No CPU has a valid candidate.
- R2: Bit 0 of the control register at 0x000 gates forwarding. While it is 0, no `cand_valid` bit is set, whatever the per-ID state.
- R3: The word at 0x004 is read-only. Bits 4:0 read the number of 32-ID groups minus one, and bits 7:5 read the CPU count minus one. With the default parameters this is 0x61.
- R4: Words from 0x100 set enable bits and words from 0x180 clear them, one bit per ID and 32 IDs per word. A 1 acts and a 0 has no effect. Both words read back the enable state.
- R5: Words from 0x200 set pending bits and words from 0x280 clear them, with the same write-one rule. Both read back the pending state, and for IDs 0-15 the read shows the OR over all CPUs. Writes to these words for IDs 0-15 are ignored.
- R6: Byte 0x400+ID holds the priority. Only its upper 4 bits are stored and the lower 4 bits read as 0. Among the eligible IDs, the lowest value wins, and a tie goes to the lowest ID.
- R7: Byte 0x800+ID holds one target bit per CPU (bit n is CPU n). An ID whose target is all zero is never offered. Target bytes of IDs 0-15 read 0 and ignore writes.
- R8: Words from 0xC00 hold 2 bits per ID, 16 IDs per word. Bit 2k+1 selects edge (1) or level (0) for ID k of that word. IDs 0-15 always read 0b10 and IDs 16-31 always read 0b00. Writes change only IDs 32 and up.
- R9: An edge ID latches pending at a rising input and keeps it after the input falls. A level ID reads pending while its input is high.
- R10: A write to 0xF00 makes software interrupt bits 3:0 pending for every CPU whose bit is set in bits 23:16.
- R11: A `cpu_take` pulse while the candidate is valid clears that ID's pending state and sets its active state. For IDs 0-15 this applies only to that CPU. Active IDs are never offered. Active state reads at 0x300.
- R12: A `cpu_done` pulse clears the active state of `cpu_done_id`. For IDs 0-15 it clears only that CPU's copy. A pending latched while the ID was active is then offered again.
- R13: `cand_id` and `cand_prio` carry the winning ID and its stored 4-bit priority for each CPU, packed CPU 0 in the low bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address |
| bus_be | input | 4 | Byte enables for writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational, zero when not reading |
| periph_in | input | 48 | Peripheral lines for IDs 16 to 63, bit 0 = ID 16 |
| cand_valid | output | 4 | Per CPU: a candidate is offered |
| cand_id | output | 24 | Per CPU 6-bit candidate ID |
| cand_prio | output | 16 | Per CPU 4-bit candidate priority |
| cpu_take | input | 4 | Per CPU: claim the offered candidate |
| cpu_done | input | 4 | Per CPU: end the active state of cpu_done_id |
| cpu_done_id | input | 24 | Per CPU 6-bit ID to end |

## Verification
The hardest state to reach is an edge interrupt that is both active and pending at once. This state must stay hidden from its CPU until the done pulse, and only then be offered again. The bench claims a shared edge interrupt with a take pulse and then drives a fresh rising pulse on its line. It reads back pending and active, and checks that the candidate stays invalid. Finally it sends the done pulse and watches the same ID come back. A similar per-CPU case is built with one software interrupt aimed at two CPUs: one CPU claims and finishes it, while the other CPU's copy must remain on offer.

// File: rtl/irq_dist_pkg.sv
package irq_dist_pkg;
   // register word indices (byte offset / 4)
   localparam int unsigned OFS_CTRL  = 32'h000;
   localparam int unsigned OFS_INFO  = 32'h001;
   localparam int unsigned OFS_ENSET = 32'h040;
   localparam int unsigned OFS_ENCLR = 32'h060;
   localparam int unsigned OFS_PNSET = 32'h080;
   localparam int unsigned OFS_PNCLR = 32'h0A0;
   localparam int unsigned OFS_ACT   = 32'h0C0;
   localparam int unsigned OFS_PRIO  = 32'h100;
   localparam int unsigned OFS_TGT   = 32'h200;
   localparam int unsigned OFS_CFG   = 32'h300;
   localparam int unsigned OFS_SWI   = 32'h3C0;
   localparam int unsigned NUM_SWI   = 16;
   localparam int unsigned FIRST_SHR = 32;
endpackage

// File: rtl/irq_pend_state.sv
module irq_pend_state #(
   parameter int unsigned NUM_IDS  = 64,
   parameter int unsigned NUM_CPUS = 4,
   parameter int unsigned NUM_SWI  = 16
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [NUM_IDS-1:0]           line_in,
   input  logic [NUM_IDS-1:0]           is_edge,
   input  logic [NUM_IDS-1:0]           pn_set,
   input  logic [NUM_IDS-1:0]           pn_clr,
   input  logic [NUM_IDS-1:0]           take_mask,
   input  logic [NUM_IDS-1:0]           done_mask,
   input  logic [NUM_CPUS*NUM_SWI-1:0]  swi_set,
   input  logic [NUM_CPUS*NUM_SWI-1:0]  swi_take,
   input  logic [NUM_CPUS*NUM_SWI-1:0]  swi_done,
   output logic [NUM_IDS-1:0]           pend_view,
   output logic [NUM_IDS-1:0]           act_view,
   output logic [NUM_CPUS*NUM_SWI-1:0]  swi_pend,
   output logic [NUM_CPUS*NUM_SWI-1:0]  swi_act
);
   logic [NUM_IDS-1:0] line_q, pend_q, act_q, rise;
   logic [NUM_SWI-1:0] swi_pend_or, swi_act_or;

   assign rise = line_in & ~line_q & is_edge;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         line_q   <= '0;
         pend_q   <= '0;
         act_q    <= '0;
         swi_pend <= '0;
         swi_act  <= '0;
      end else begin
         line_q   <= line_in;
         pend_q   <= (pend_q & ~pn_clr & ~take_mask) | pn_set | rise;
         act_q    <= (act_q & ~done_mask) | take_mask;
         swi_pend <= (swi_pend & ~swi_take) | swi_set;
         swi_act  <= (swi_act & ~swi_done) | swi_take;
      end
   end

   always_comb begin
      swi_pend_or = '0;
      swi_act_or  = '0;
      for (int unsigned c = 0; c < NUM_CPUS; c++) begin
         swi_pend_or = swi_pend_or | swi_pend[c*NUM_SWI +: NUM_SWI];
         swi_act_or  = swi_act_or  | swi_act[c*NUM_SWI +: NUM_SWI];
      end
   end

   assign pend_view = pend_q | (line_in & ~is_edge) | NUM_IDS'(swi_pend_or);
   assign act_view  = act_q | NUM_IDS'(swi_act_or);
endmodule

// File: rtl/irq_pick.sv
module irq_pick #(
   parameter int unsigned NUM_IDS   = 64,
   parameter int unsigned PRIO_BITS = 4,
   localparam int unsigned IDW      = $clog2(NUM_IDS)
) (
   input  logic [NUM_IDS-1:0]           elig,
   input  logic [NUM_IDS*PRIO_BITS-1:0] prio_flat,
   output logic                         win_valid,
   output logic [IDW-1:0]               win_id,
   output logic [PRIO_BITS-1:0]         win_prio
);
   // ascending scan with strict compare keeps the lowest ID on a tie
   always_comb begin
      win_valid = 1'b0;
      win_id    = '0;
      win_prio  = '0;
      for (int unsigned i = 0; i < NUM_IDS; i++) begin
         if (elig[i] && (!win_valid || prio_flat[i*PRIO_BITS +: PRIO_BITS] < win_prio)) begin
            win_valid = 1'b1;
            win_id    = IDW'(i);
            win_prio  = prio_flat[i*PRIO_BITS +: PRIO_BITS];
         end
      end
   end
endmodule

// File: rtl/irq_distributor.sv
module irq_distributor
   import irq_dist_pkg::*;
#(
   parameter int unsigned NUM_IDS   = 64,
   parameter int unsigned NUM_CPUS  = 4,
   parameter int unsigned PRIO_BITS = 4,
   parameter int unsigned ADDR_W    = 12
) (
   input  logic                                  clk,
   input  logic                                  rst_n,
   input  logic                                  bus_sel,
   input  logic                                  bus_wr,
   input  logic [ADDR_W-1:0]                     bus_addr,
   input  logic [3:0]                            bus_be,
   input  logic [31:0]                           bus_wdata,
   output logic [31:0]                           bus_rdata,
   input  logic [NUM_IDS-17:0]                   periph_in,
   output logic [NUM_CPUS-1:0]                   cand_valid,
   output logic [NUM_CPUS*$clog2(NUM_IDS)-1:0]   cand_id,
   output logic [NUM_CPUS*PRIO_BITS-1:0]         cand_prio,
   input  logic [NUM_CPUS-1:0]                   cpu_take,
   input  logic [NUM_CPUS-1:0]                   cpu_done,
   input  logic [NUM_CPUS*$clog2(NUM_IDS)-1:0]   cpu_done_id
);
   localparam int unsigned IDW    = $clog2(NUM_IDS);
   localparam int unsigned GROUPS = NUM_IDS / 32;
   localparam int unsigned PLO    = 8 - PRIO_BITS;

   // elaboration-time parameter checks
   if (NUM_IDS % 32 != 0 || NUM_IDS < 32 || NUM_IDS > 1024) begin : g_bad_ids
      $error("NUM_IDS must be a multiple of 32 between 32 and 1024");
   end
   if (NUM_CPUS < 1 || NUM_CPUS > 8) begin : g_bad_cpus
      $error("NUM_CPUS must be 1 to 8");
   end
   if (PRIO_BITS < 1 || PRIO_BITS > 8) begin : g_bad_prio
      $error("PRIO_BITS must be 1 to 8");
   end
   if (ADDR_W < 12) begin : g_bad_addr
      $error("ADDR_W must be at least 12");
   end

   // configuration state
   logic                          ctrl_en;
   logic [NUM_IDS-1:0]            en_q;
   logic [NUM_IDS*PRIO_BITS-1:0]  prio_q;
   logic [NUM_IDS*NUM_CPUS-1:0]   tgt_flat;
   logic [NUM_IDS-1:0]            edge_q;

   // bus decode
   logic                          acc_ok, wr_go, ctrl_wr, swi_go;
   int unsigned                   word;
   logic [NUM_IDS-1:0]            en_set, en_clr, pn_set, pn_clr, prio_wr, tgt_wr, cfg_wr;
   logic [31:0]                   rd;

   assign acc_ok  = bus_sel && (bus_addr[1:0] == 2'b00);
   assign wr_go   = acc_ok && bus_wr;
   assign word    = 32'(bus_addr[ADDR_W-1:2]);
   assign ctrl_wr = wr_go && word == OFS_CTRL && bus_be[0];
   assign swi_go  = wr_go && word == OFS_SWI;

   always_comb begin
      for (int unsigned i = 0; i < NUM_IDS; i++) begin
         en_set[i]  = wr_go && word == OFS_ENSET + i/32 && bus_be[(i%32)/8] && bus_wdata[i%32];
         en_clr[i]  = wr_go && word == OFS_ENCLR + i/32 && bus_be[(i%32)/8] && bus_wdata[i%32];
         pn_set[i]  = (i >= NUM_SWI) && wr_go && word == OFS_PNSET + i/32
                      && bus_be[(i%32)/8] && bus_wdata[i%32];
         pn_clr[i]  = (i >= NUM_SWI) && wr_go && word == OFS_PNCLR + i/32
                      && bus_be[(i%32)/8] && bus_wdata[i%32];
         prio_wr[i] = wr_go && word == OFS_PRIO + i/4 && bus_be[i%4];
         tgt_wr[i]  = (i >= NUM_SWI) && wr_go && word == OFS_TGT + i/4 && bus_be[i%4];
         cfg_wr[i]  = (i >= FIRST_SHR) && wr_go && word == OFS_CFG + i/16 && bus_be[(i%16)/4];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_en  <= 1'b0;
         en_q     <= '0;
         prio_q   <= '0;
         tgt_flat <= '0;
         edge_q   <= NUM_IDS'({NUM_SWI{1'b1}});
      end else begin
         if (ctrl_wr) ctrl_en <= bus_wdata[0];
         en_q <= (en_q & ~en_clr) | en_set;
         for (int unsigned i = 0; i < NUM_IDS; i++) begin
            if (prio_wr[i])
               prio_q[i*PRIO_BITS +: PRIO_BITS] <= bus_wdata[(i%4)*8 + PLO +: PRIO_BITS];
            if (tgt_wr[i])
               tgt_flat[i*NUM_CPUS +: NUM_CPUS] <= bus_wdata[(i%4)*8 +: NUM_CPUS];
            if (cfg_wr[i])
               edge_q[i] <= bus_wdata[(i%16)*2 + 1];
         end
      end
   end

   // per-ID dynamic state
   logic [NUM_IDS-1:0]            line_in, pend_view, act_view, take_mask, done_mask;
   logic [NUM_CPUS*NUM_SWI-1:0]   swi_set, swi_take, swi_done, swi_pend, swi_act;

   assign line_in = {periph_in, {NUM_SWI{1'b0}}};

   always_comb begin
      logic [IDW-1:0] tid;
      logic [IDW-1:0] did;
      take_mask = '0;
      done_mask = '0;
      swi_set   = '0;
      swi_take  = '0;
      swi_done  = '0;
      for (int unsigned c = 0; c < NUM_CPUS; c++) begin
         tid = cand_id[c*IDW +: IDW];
         did = cpu_done_id[c*IDW +: IDW];
         if (swi_go && bus_wdata[16 + c])
            swi_set[c*NUM_SWI + 32'(bus_wdata[3:0])] = 1'b1;
         if (cpu_take[c] && cand_valid[c]) begin
            if (32'(tid) < NUM_SWI) swi_take[c*NUM_SWI + 32'(tid)] = 1'b1;
            else                    take_mask[tid] = 1'b1;
         end
         if (cpu_done[c] && 32'(did) < NUM_IDS) begin
            if (32'(did) < NUM_SWI) swi_done[c*NUM_SWI + 32'(did)] = 1'b1;
            else                    done_mask[did] = 1'b1;
         end
      end
   end

   irq_pend_state #(
      .NUM_IDS  (NUM_IDS),
      .NUM_CPUS (NUM_CPUS),
      .NUM_SWI  (NUM_SWI)
   ) u_state (
      .clk       (clk),
      .rst_n     (rst_n),
      .line_in   (line_in),
      .is_edge   (edge_q),
      .pn_set    (pn_set),
      .pn_clr    (pn_clr),
      .take_mask (take_mask),
      .done_mask (done_mask),
      .swi_set   (swi_set),
      .swi_take  (swi_take),
      .swi_done  (swi_done),
      .pend_view (pend_view),
      .act_view  (act_view),
      .swi_pend  (swi_pend),
      .swi_act   (swi_act)
   );

   // per-CPU eligibility and arbitration
   logic [NUM_IDS-1:0] elig [NUM_CPUS];

   always_comb begin
      for (int unsigned c = 0; c < NUM_CPUS; c++) begin
         for (int unsigned i = 0; i < NUM_IDS; i++) begin
            if (i < NUM_SWI)
               elig[c][i] = ctrl_en && en_q[i] && swi_pend[c*NUM_SWI + i]
                            && !swi_act[c*NUM_SWI + i];
            else
               elig[c][i] = ctrl_en && en_q[i] && pend_view[i] && !act_view[i]
                            && tgt_flat[i*NUM_CPUS + c];
         end
      end
   end

   for (genvar c = 0; c < NUM_CPUS; c++) begin : g_cpu
      irq_pick #(
         .NUM_IDS   (NUM_IDS),
         .PRIO_BITS (PRIO_BITS)
      ) u_pick (
         .elig      (elig[c]),
         .prio_flat (prio_q),
         .win_valid (cand_valid[c]),
         .win_id    (cand_id[c*IDW +: IDW]),
         .win_prio  (cand_prio[c*PRIO_BITS +: PRIO_BITS])
      );
   end

   // read mux
   always_comb begin
      rd = '0;
      if (word == OFS_CTRL) rd[0] = ctrl_en;
      if (word == OFS_INFO) begin
         rd[4:0] = 5'(GROUPS - 1);
         rd[7:5] = 3'(NUM_CPUS - 1);
      end
      for (int unsigned i = 0; i < NUM_IDS; i++) begin
         if (word == OFS_ENSET + i/32 || word == OFS_ENCLR + i/32) rd[i%32] = en_q[i];
         if (word == OFS_PNSET + i/32 || word == OFS_PNCLR + i/32) rd[i%32] = pend_view[i];
         if (word == OFS_ACT + i/32) rd[i%32] = act_view[i];
         if (word == OFS_PRIO + i/4)
            rd[(i%4)*8 + PLO +: PRIO_BITS] = prio_q[i*PRIO_BITS +: PRIO_BITS];
         if (word == OFS_TGT + i/4)
            rd[(i%4)*8 +: NUM_CPUS] = tgt_flat[i*NUM_CPUS +: NUM_CPUS];
         if (word == OFS_CFG + i/16) rd[(i%16)*2 + 1] = edge_q[i];
      end
   end

   assign bus_rdata = (acc_ok && !bus_wr) ? rd : 32'h0;
endmodule

// File: rtl/irq_dist_checker.sv
module irq_dist_checker
   import irq_dist_pkg::*;
#(
   parameter int unsigned NUM_IDS   = 64,
   parameter int unsigned NUM_CPUS  = 4,
   parameter int unsigned ADDR_W    = 12,
   localparam int unsigned IDW      = $clog2(NUM_IDS)
) (
   input logic                          clk,
   input logic                          rst_n,
   input logic                          ctrl_en,
   input logic [NUM_IDS-1:0]            en_q,
   input logic [NUM_IDS*NUM_CPUS-1:0]   tgt_flat,
   input logic [NUM_CPUS*16-1:0]        swi_pend,
   input logic                          bus_sel,
   input logic                          bus_wr,
   input logic [ADDR_W-1:0]             bus_addr,
   input logic [31:0]                   bus_wdata,
   input logic [NUM_CPUS-1:0]           cand_valid,
   input logic [NUM_CPUS*IDW-1:0]       cand_id,
   input logic [NUM_CPUS-1:0]           cpu_take,
   input logic [NUM_CPUS-1:0]           cpu_done
);
   logic swi_wr;
   assign swi_wr = bus_sel && bus_wr && bus_addr[1:0] == 2'b00
                   && 32'(bus_addr[ADDR_W-1:2]) == OFS_SWI;

   for (genvar c = 0; c < NUM_CPUS; c++) begin : g_chk
      logic [IDW-1:0] cid;
      assign cid = cand_id[c*IDW +: IDW];

      a_r2_gate_off: assert property (@(posedge clk) disable iff (!rst_n)
         !ctrl_en |-> !cand_valid[c]);

      a_r4_cand_enabled: assert property (@(posedge clk) disable iff (!rst_n)
         cand_valid[c] |-> en_q[cid]);

      a_r7_cand_targeted: assert property (@(posedge clk) disable iff (!rst_n)
         (cand_valid[c] && 32'(cid) >= 16) |-> tgt_flat[32'(cid)*NUM_CPUS + c]);

      a_r10_swi_latch: assert property (@(posedge clk) disable iff (!rst_n)
         (swi_wr && bus_wdata[16 + c]) |=> swi_pend[c*16 + 32'($past(bus_wdata[3:0]))]);

      a_r11_no_reoffer: assert property (@(posedge clk) disable iff (!rst_n)
         (cpu_take[c] && cand_valid[c] && cpu_done == '0)
         |=> !(cand_valid[c] && cid == $past(cid)));
   end
endmodule

bind irq_distributor irq_dist_checker #(
   .NUM_IDS  (NUM_IDS),
   .NUM_CPUS (NUM_CPUS),
   .ADDR_W   (ADDR_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .ctrl_en    (ctrl_en),
   .en_q       (en_q),
   .tgt_flat   (tgt_flat),
   .swi_pend   (swi_pend),
   .bus_sel    (bus_sel),
   .bus_wr     (bus_wr),
   .bus_addr   (bus_addr),
   .bus_wdata  (bus_wdata),
   .cand_valid (cand_valid),
   .cand_id    (cand_id),
   .cpu_take   (cpu_take),
   .cpu_done   (cpu_done)
);

// File: tb/tb_irq_distributor.sv
module tb_irq_distributor;
   localparam int NI = 64;
   localparam int NC = 4;
   localparam int IW = 6;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              bus_sel = 1'b0;
   logic              bus_wr = 1'b0;
   logic [11:0]       bus_addr = '0;
   logic [3:0]        bus_be = '0;
   logic [31:0]       bus_wdata = '0;
   logic [31:0]       bus_rdata;
   logic [NI-17:0]    periph_in = '0;
   logic [NC-1:0]     cand_valid;
   logic [NC*IW-1:0]  cand_id;
   logic [NC*4-1:0]   cand_prio;
   logic [NC-1:0]     cpu_take = '0;
   logic [NC-1:0]     cpu_done = '0;
   logic [NC*IW-1:0]  cpu_done_id = '0;

   int n_chk = 0;
   int n_fail = 0;

   always #5 clk = ~clk;

   irq_distributor dut (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .periph_in(periph_in), .cand_valid(cand_valid),
      .cand_id(cand_id), .cand_prio(cand_prio), .cpu_take(cpu_take),
      .cpu_done(cpu_done), .cpu_done_id(cpu_done_id)
   );

   task automatic chk(input string req, input string what,
                      input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s %s got=%h exp=%h", req, what, got, exp);
      end
   endtask

   task automatic bw(input logic [11:0] a, input logic [31:0] d, input logic [3:0] be);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_be = be;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0; bus_be = '0;
   endtask

   task automatic br(input logic [11:0] a, output logic [31:0] d);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      #1;
      d = bus_rdata;
      bus_sel = 1'b0;
   endtask

   function automatic logic [31:0] cid(input int c);
      return 32'(cand_id[c*IW +: IW]);
   endfunction

   task automatic take(input int c);
      @(negedge clk); cpu_take[c] = 1'b1;
      @(negedge clk); cpu_take[c] = 1'b0;
      #1;
   endtask

   task automatic done(input int c, input int id);
      @(negedge clk); cpu_done[c] = 1'b1; cpu_done_id[c*IW +: IW] = IW'(id);
      @(negedge clk); cpu_done[c] = 1'b0;
      #1;
   endtask

   task automatic quiesce();
      periph_in = '0;
      bw(12'h180, 32'hFFFF_FFFF, 4'hF);
      bw(12'h184, 32'hFFFF_FFFF, 4'hF);
      bw(12'h280, 32'hFFFF_FFFF, 4'hF);
      bw(12'h284, 32'hFFFF_FFFF, 4'hF);
   endtask

   task automatic t_reset();
      logic [31:0] d;
      br(12'h000, d); chk("R1", "ctrl after reset", d, 0);
      br(12'h104, d); chk("R1", "enable after reset", d, 0);
      br(12'h400, d); chk("R1", "prio after reset", d, 0);
      chk("R1", "cand_valid after reset", 32'(cand_valid), 0);
      br(12'h004, d); chk("R3", "info word", d, 32'h61);
      bw(12'h004, 32'hFFFF_FFFF, 4'hF);
      br(12'h004, d); chk("R3", "info word after write", d, 32'h61);
   endtask

   task automatic t_enable();
      logic [31:0] d;
      bw(12'h104, 32'h100, 4'hF);
      br(12'h104, d); chk("R4", "set-enable id40", d, 32'h100);
      br(12'h184, d); chk("R4", "clear word reads enable", d, 32'h100);
      bw(12'h184, 32'h0, 4'hF);
      br(12'h104, d); chk("R4", "zero clear no effect", d, 32'h100);
      bw(12'h184, 32'h100, 4'hF);
      br(12'h104, d); chk("R4", "clear-enable id40", d, 0);
   endtask

   task automatic t_fields();
      logic [31:0] d;
      bw(12'h428, 32'hFFFF_FFFF, 4'b0001);
      br(12'h428, d); chk("R6", "prio low bits zero, lane mask", d, 32'h0000_00F0);
      bw(12'h428, 32'h0, 4'hF);
      bw(12'h804, 32'hFFFF_FFFF, 4'hF);
      br(12'h804, d); chk("R7", "swi target ignores write", d, 0);
      bw(12'h828, 32'hFFFF_FFFF, 4'hF);
      br(12'h828, d); chk("R7", "target bytes id40-43", d, 32'h0F0F_0F0F);
      bw(12'h828, 32'h0, 4'hF);
      br(12'h C00, d); chk("R8", "swi config fixed edge", d, 32'hAAAA_AAAA);
      bw(12'hC00, 32'h0, 4'hF);
      br(12'hC00, d); chk("R8", "swi config after write", d, 32'hAAAA_AAAA);
      bw(12'hC04, 32'hFFFF_FFFF, 4'hF);
      br(12'hC04, d); chk("R8", "per-cpu config fixed level", d, 0);
   endtask

   task automatic t_level();
      logic [31:0] d;
      bw(12'h000, 32'h1, 4'h1);
      bw(12'h104, 32'h100, 4'hF);
      bw(12'h428, 32'h30, 4'b0001);
      bw(12'h828, 32'h02, 4'b0001);
      @(negedge clk); periph_in[24] = 1'b1; #1;
      chk("R9", "level cand_valid", 32'(cand_valid), 32'b0010);
      chk("R13", "level cand_id cpu1", cid(1), 40);
      chk("R13", "level cand_prio cpu1", 32'(cand_prio[7:4]), 3);
      br(12'h204, d); chk("R9", "level pending read", d, 32'h100);
      bw(12'h000, 32'h0, 4'h1); #1;
      chk("R2", "ctrl off blocks", 32'(cand_valid), 0);
      bw(12'h000, 32'h1, 4'h1); #1;
      chk("R2", "ctrl on restores", 32'(cand_valid), 32'b0010);
      @(negedge clk); periph_in[24] = 1'b0; #1;
      chk("R9", "level drop clears", 32'(cand_valid), 0);
      br(12'h204, d); chk("R9", "level pending after drop", d, 0);
      quiesce();
   endtask

   task automatic t_edge();
      logic [31:0] d;
      bw(12'hC08, 32'h0008_0000, 4'b0100);
      br(12'hC08, d); chk("R8", "id41 edge config", d, 32'h0008_0000);
      bw(12'h104, 32'h200, 4'hF);
      bw(12'h428, 32'h5000, 4'b0010);
      bw(12'h828, 32'h0100, 4'b0010);
      @(negedge clk); periph_in[25] = 1'b1;
      @(negedge clk); periph_in[25] = 1'b0;
      @(negedge clk); #1;
      chk("R9", "edge latched valid", 32'(cand_valid), 32'b0001);
      chk("R9", "edge latched id", cid(0), 41);
      br(12'h204, d); chk("R9", "edge pending after low", d, 32'h200);
      bw(12'h284, 32'h200, 4'hF); #1;
      chk("R5", "clear-pending drops cand", 32'(cand_valid), 0);
      br(12'h204, d); chk("R5", "clear-pending read", d, 0);
   endtask

   task automatic t_take_shared();
      logic [31:0] d;
      bw(12'h204, 32'h200, 4'hF); #1;
      chk("R5", "set-pending offers id41", cid(0), 41);
      take(0);
      chk("R11", "taken not offered", 32'(cand_valid), 0);
      br(12'h304, d); chk("R11", "active id41", d, 32'h200);
      br(12'h204, d); chk("R11", "pending cleared by take", d, 0);
      @(negedge clk); periph_in[25] = 1'b1;
      @(negedge clk); periph_in[25] = 1'b0;
      @(negedge clk); #1;
      br(12'h204, d); chk("R11", "pending while active", d, 32'h200);
      chk("R11", "active+pending hidden", 32'(cand_valid), 0);
      done(0, 41);
      br(12'h304, d); chk("R12", "active cleared", d, 0);
      chk("R12", "re-offered after done", 32'(cand_valid), 32'b0001);
      chk("R12", "re-offered id", cid(0), 41);
      quiesce();
   endtask

   task automatic t_arb();
      bw(12'h830, 32'h0404_0000, 4'b1100);
      bw(12'h430, 32'h2040_0000, 4'b1100);
      bw(12'h104, 32'h000C_0000, 4'hF);
      bw(12'h204, 32'h000C_0000, 4'hF); #1;
      chk("R6", "lower prio value wins", cid(2), 51);
      chk("R13", "winner prio", 32'(cand_prio[11:8]), 2);
      bw(12'h430, 32'h0020_0000, 4'b0100); #1;
      chk("R6", "tie lowest id", cid(2), 50);
      chk("R6", "only cpu2 offered", 32'(cand_valid), 32'b0100);
      quiesce();
   endtask

   task automatic t_zero_target();
      logic [31:0] d;
      bw(12'h104, 32'h1000_0000, 4'hF);
      bw(12'h204, 32'h1000_0000, 4'hF); #1;
      br(12'h204, d); chk("R7", "id60 pending", d, 32'h1000_0000);
      chk("R7", "zero target not offered", 32'(cand_valid), 0);
      quiesce();
   endtask

   task automatic t_swi();
      logic [31:0] d;
      bw(12'h200, 32'h8, 4'hF);
      br(12'h200, d); chk("R5", "swi set-pending ignored", d, 0);
      bw(12'h100, 32'h8, 4'hF);
      bw(12'h400, 32'h1000_0000, 4'b1000);
      bw(12'hF00, 32'h0005_0003, 4'hF); #1;
      chk("R10", "swi cpus 0 and 2", 32'(cand_valid), 32'b0101);
      chk("R10", "swi id cpu0", cid(0), 3);
      chk("R10", "swi id cpu2", cid(2), 3);
      br(12'h200, d); chk("R10", "swi pending read", d, 32'h8);
      bw(12'h280, 32'h8, 4'hF);
      br(12'h200, d); chk("R5", "swi clear-pending ignored", d, 32'h8);
      take(0);
      chk("R11", "cpu0 swi taken", 32'(cand_valid), 32'b0100);
      br(12'h300, d); chk("R11", "swi active", d, 32'h8);
      done(0, 3);
      br(12'h300, d); chk("R12", "swi active cleared", d, 0);
      chk("R12", "cpu2 copy still offered", cid(2), 3);
      chk("R12", "cpu0 not re-offered", 32'(cand_valid), 32'b0100);
      take(2);
      done(2, 3);
      chk("R11", "all swi serviced", 32'(cand_valid), 0);
   endtask

   initial begin
      #1_000_000;
      n_fail++;
      $display("FAIL R1 watchdog got=timeout exp=finish");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk); #1;
      t_reset();
      t_enable();
      t_fields();
      t_level();
      t_edge();
      t_take_shared();
      t_arb();
      t_zero_target();
      t_swi();
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end
endmodule